// File: doc/BRIEF.md
# TDM Bus Clock Generator

This block produces the family of clocks that a time-division-multiplexed backplane needs. It derives them from a fast system clock and the sampled bus clock and frame pulse. The bus clock nominally runs at 8.192 MHz and the frame pulse at 8 kHz. The outputs are:

- the serial bit clock `sclk`, at 8.192, 4.096 or 2.048 MHz;
- its double-rate companion `sclkx2`, with the same or the opposite polarity to `sclk`;
- the legacy compatibility clocks `c2` and `c4`;
- a complementary 16.384 MHz pair, `c16_p` and `c16_n`.

A phase counter runs on the system clock, which is eight times the bus clock (65.536 MHz with the defaults). Every output is a registered tap of that counter. Each frame pulse reloads the counter, so all output edges line up with the frame boundary. The rate and polarity inputs are captured only at a frame boundary. A host can therefore change them at any time without shortening a clock pulse in the middle of a frame.

Top module: `tdm_clk_gen`

## Requirements

Definitions used below:

- All periods are in system clock cycles, with the default of 8 system clocks per bus period.
- Edge n is a frame boundary. Edge m is any later system clock edge, and e = m − n.
- A clock of period P "follows the pattern" when, after edge m, it is high for e mod P < P/2 and low otherwise.

Requirements:

- R1: While `rst_n` is low, `sclk`, `sclkx2`, `c2`, `c4` and `c16_p` are 0 and `c16_n` is 1.
- R2: `sclk` follows the pattern with P = 8 when `cfg_rate` = 2'b00, P = 16 for 2'b01, and P = 32 for 2'b10 and 2'b11.
- R3: With `cfg_inv` = 0, `sclkx2` follows the pattern with half the `sclk` period: P = 4, 8 or 16 for the three rates. Every `sclk` edge is therefore an `sclkx2` edge.
- R4: With `cfg_inv` = 1, `sclkx2` is the complement of the R3 waveform, so it is low whenever `sclk` rises.
- R5: `c4` follows the pattern with P = 16 and `c2` with P = 32, whatever the rate setting.
- R6: `c16_p` follows the pattern with P = 4.
- R7: `c16_n` is the complement of `c16_p` on every cycle.
- R8: A frame boundary is the first system clock edge at which `bus_clk` is sampled high while `bus_frame_n` is low. From edge n+3 on, every output follows its pattern, even when the phase before the boundary was different.
- R9: `cfg_rate` and `cfg_inv` are captured only at a frame boundary. A change between boundaries has no effect on any output until edge n+3 of the next boundary.
- R10: Between boundaries the outputs run continuously. A frame pulse that arrives in phase with the running counter causes no visible disturbance.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, SYS_PER_BUS times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus clock, synchronised internally |
| bus_frame_n | input | 1 | Active-low frame pulse, one bus period wide |
| cfg_rate | input | 2 | Bit clock rate code: 00 = 8.192 MHz, 01 = 4.096 MHz, 10/11 = 2.048 MHz |
| cfg_inv | input | 1 | 1 = `sclkx2` has the opposite polarity to `sclk` |
| sclk | output | 1 | Serial bit clock |
| sclkx2 | output | 1 | Double-rate bit clock |
| c2 | output | 1 | Compatibility clock, one quarter of the bus rate |
| c4 | output | 1 | Compatibility clock, one half of the bus rate |
| c16_p | output | 1 | Compatibility clock, twice the bus rate |
| c16_n | output | 1 | Complement of `c16_p` |

## Verification

On every cycle the assertions check the relations between the outputs that hold away from a realignment:

- `c16_n` is the complement of `c16_p`;
- every `sclk` edge coincides with an `sclkx2` edge, with the polarity the active setting demands;
- `c2` and `c4` change only together with the faster clocks;
- the captured configuration changes only after a frame strobe.

The absolute phase of each clock relative to the frame pulse needs the bench's scenarios. So do the exact periods for each rate code, the jump of phase after a misaligned frame, and the deferral of a mid-frame configuration change.

// File: rtl/tdm_clk_pkg.sv
package tdm_clk_pkg;

   typedef enum logic [1:0] {
      RATE_8M     = 2'b00,
      RATE_4M     = 2'b01,
      RATE_2M     = 2'b10,
      RATE_2M_ALT = 2'b11
   } rate_e;

   typedef struct packed {
      rate_e rate;
      logic  inv;
   } clk_cfg_t;

   localparam clk_cfg_t CFG_DEFAULT = '{rate: RATE_8M, inv: 1'b0};

   typedef struct packed {
      logic sclk;
      logic sclkx2;
      logic c2;
      logic c4;
      logic c16_p;
      logic c16_n;
   } clk_out_t;

   // Output values held while reset is active.
   localparam clk_out_t OUT_RESET = '{sclk: 1'b0, sclkx2: 1'b0, c2: 1'b0,
                                      c4: 1'b0, c16_p: 1'b0, c16_n: 1'b1};

   // Number of halvings of the bit clock below the bus rate.
   function automatic logic [1:0] rate_shift(rate_e r);
      case (r)
         RATE_8M: rate_shift = 2'd0;
         RATE_4M: rate_shift = 2'd1;
         default: rate_shift = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tdm_frame_det.sv
module tdm_frame_det (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_s,
   input  logic frame_n_s,
   output logic strobe
);

   logic bus_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_prev_q <= 1'b0;
      else        bus_prev_q <= bus_s;
   end

   // Rising edge of the bus clock while the frame pulse is asserted.
   assign strobe = bus_s & ~bus_prev_q & ~frame_n_s;

endmodule

// File: rtl/tdm_phase_ctr.sv
module tdm_phase_ctr #(
   parameter int PH_W     = 5,
   parameter int LOAD_VAL = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   output logic [PH_W-1:0] phase
);

   localparam logic [PH_W-1:0] LOAD_V = PH_W'(LOAD_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase <= '0;
      else if (load) phase <= LOAD_V;
      else           phase <= phase + 1'b1;
   end

endmodule

// File: rtl/tdm_cfg_hold.sv
module tdm_cfg_hold
   import tdm_clk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     capture,
   input  clk_cfg_t cfg_in,
   output clk_cfg_t cfg_act
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_act <= CFG_DEFAULT;
      else if (capture) cfg_act <= cfg_in;
   end

endmodule

// File: rtl/tdm_clk_taps.sv
module tdm_clk_taps
   import tdm_clk_pkg::*;
#(
   parameter int LOG_SPB = 3,
   parameter int PH_W    = LOG_SPB + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] phase,
   input  clk_cfg_t        cfg,
   output clk_out_t        outs
);

   localparam int N_RATES = 3;

   logic [N_RATES-1:0] sclk_cand;
   logic [N_RATES-1:0] x2_cand;
   logic [1:0]         sh;
   clk_out_t           nxt;

   // One candidate tap per selectable rate; sclkx2 sits one bit lower.
   for (genvar g = 0; g < N_RATES; g++) begin : g_tap
      assign sclk_cand[g] = ~phase[LOG_SPB-1+g];
      assign x2_cand[g]   = ~phase[LOG_SPB-2+g];
   end

   assign sh = rate_shift(cfg.rate);

   always_comb begin
      nxt.sclk   = sclk_cand[sh];
      nxt.sclkx2 = x2_cand[sh] ^ cfg.inv;
      nxt.c16_p  = ~phase[LOG_SPB-2];
      nxt.c16_n  = phase[LOG_SPB-2];
      nxt.c4     = ~phase[LOG_SPB];
      nxt.c2     = ~phase[LOG_SPB+1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outs <= OUT_RESET;
      else        outs <= nxt;
   end

endmodule

// File: rtl/tdm_clk_gen.sv
module tdm_clk_gen
   import tdm_clk_pkg::*;
#(
   parameter int SYS_PER_BUS = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_clk,
   input  logic       bus_frame_n,
   input  logic [1:0] cfg_rate,
   input  logic       cfg_inv,
   output logic       sclk,
   output logic       sclkx2,
   output logic       c2,
   output logic       c4,
   output logic       c16_p,
   output logic       c16_n
);

   localparam int LOG_SPB  = $clog2(SYS_PER_BUS);
   localparam int PH_W     = LOG_SPB + 2;
   // Reload value that absorbs synchroniser, strobe and output register delay.
   localparam int LOAD_VAL = SYNC_STAGES + 1;

   if (SYS_PER_BUS < 4 || (SYS_PER_BUS & (SYS_PER_BUS - 1)) != 0) begin : g_bad_spb
      $error("SYS_PER_BUS must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (LOAD_VAL >= (1 << PH_W)) begin : g_bad_load
      $error("SYNC_STAGES too large for the phase counter");
   end

   logic [1:0]      sync_q;
   logic            bus_s;
   logic            frame_n_s;
   logic            frame_strobe;
   logic [PH_W-1:0] phase;
   clk_cfg_t        cfg_in;
   clk_cfg_t        cfg_act;
   clk_out_t        outs;
   logic [1:0]      act_rate;
   logic            act_inv;

   tdm_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_clk, bus_frame_n}),
      .q     (sync_q)
   );

   assign bus_s     = sync_q[1];
   assign frame_n_s = sync_q[0];

   tdm_frame_det u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_s     (bus_s),
      .frame_n_s (frame_n_s),
      .strobe    (frame_strobe)
   );

   tdm_phase_ctr #(
      .PH_W     (PH_W),
      .LOAD_VAL (LOAD_VAL)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frame_strobe),
      .phase (phase)
   );

   assign cfg_in.rate = rate_e'(cfg_rate);
   assign cfg_in.inv  = cfg_inv;

   tdm_cfg_hold u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (frame_strobe),
      .cfg_in  (cfg_in),
      .cfg_act (cfg_act)
   );

   assign act_rate = cfg_act.rate;
   assign act_inv  = cfg_act.inv;

   tdm_clk_taps #(
      .LOG_SPB (LOG_SPB),
      .PH_W    (PH_W)
   ) u_taps (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase),
      .cfg   (cfg_act),
      .outs  (outs)
   );

   assign sclk   = outs.sclk;
   assign sclkx2 = outs.sclkx2;
   assign c2     = outs.c2;
   assign c4     = outs.c4;
   assign c16_p  = outs.c16_p;
   assign c16_n  = outs.c16_n;

endmodule

// File: rtl/tdm_clk_gen_chk.sv
module tdm_clk_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sclk,
   input logic       sclkx2,
   input logic       c2,
   input logic       c4,
   input logic       c16_p,
   input logic       c16_n,
   input logic       strobe,
   input logic       act_inv,
   input logic [1:0] act_rate
);

   p_c16_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c16_n == !c16_p);

   p_x2_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sclk) && !$past(strobe, 2)) |-> !$stable(sclkx2));

   p_x2_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk) && !$past(strobe, 2)) |-> (sclkx2 == !act_inv));

   p_c2_with_c4_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(c2) && !$past(strobe, 2)) |-> !$stable(c4));

   p_c4_with_c16_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(c4) && !$past(strobe, 2)) |-> !$stable(c16_p));

   p_cfg_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_rate) || !$stable(act_inv)) |-> $past(strobe));

endmodule

bind tdm_clk_gen tdm_clk_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk     (sclk),
   .sclkx2   (sclkx2),
   .c2       (c2),
   .c4       (c4),
   .c16_p    (c16_p),
   .c16_n    (c16_n),
   .strobe   (frame_strobe),
   .act_inv  (act_inv),
   .act_rate (act_rate)
);

// File: tb/tdm_clk_gen_bench.sv
module tdm_clk_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SPB        = 8;
   localparam int LAT        = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_clk = 1'b0;
   logic       bus_frame_n = 1'b1;
   logic [1:0] cfg_rate = 2'b00;
   logic       cfg_inv = 1'b0;
   logic       sclk, sclkx2, c2, c4, c16_p, c16_n;

   tdm_clk_gen u_tdm_clk_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_clk     (bus_clk),
      .bus_frame_n (bus_frame_n),
      .cfg_rate    (cfg_rate),
      .cfg_inv     (cfg_inv),
      .sclk        (sclk),
      .sclkx2      (sclkx2),
      .c2          (c2),
      .c4          (c4),
      .c16_p       (c16_p),
      .c16_n       (c16_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      int unsigned cyc;
      logic [5:0]  v;     // sclk, sclkx2, c2, c4, c16_p, c16_n
      bit          inv;
      string       ctx;
   } item_t;

   item_t q[$];

   task automatic check_bit(string req, string ctx, string name,
                            logic got, logic exp, int unsigned at);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s got %b expected %b at cycle %0d",
                  req, ctx, name, got, exp, at);
      end
   endtask

   // Bus clock and frame pulse generator
   bit running = 1'b0;
   int bpos    = SPB - 1;
   int gap     = 0;
   int unsigned boundary;
   event frame_ev;

   always @(negedge clk) begin
      if (running) begin
         bpos    = (bpos + 1) % SPB;
         bus_clk = (bpos < SPB/2);
         if (bpos == 0) begin
            bus_frame_n = 1'b1;
            if (gap > 0) begin
               gap--;
               if (gap == 0) begin
                  bus_frame_n = 1'b0;
                  boundary    = cyc + 1;
                  ->frame_ev;
               end
            end
         end
      end
   end

   // Monitor: pops expected items and compares
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         item_t it;
         it = q.pop_front();
         if (it.cyc < cyc) begin
            checks++;
            errors++;
            $display("FAIL R10 (%s) sample missed got cycle %0d expected cycle %0d",
                     it.ctx, cyc, it.cyc);
         end else begin
            check_bit("R2", it.ctx, "sclk", sclk, it.v[5], cyc);
            check_bit(it.inv ? "R4" : "R3", it.ctx, "sclkx2", sclkx2, it.v[4], cyc);
            check_bit("R5", it.ctx, "c2", c2, it.v[3], cyc);
            check_bit("R5", it.ctx, "c4", c4, it.v[2], cyc);
            check_bit("R6", it.ctx, "c16_p", c16_p, it.v[1], cyc);
            check_bit("R7", it.ctx, "c16_n", c16_n, it.v[0], cyc);
         end
      end
   end

   function automatic logic pat(int unsigned e, int unsigned p);
      return ((e % p) < (p / 2));
   endfunction

   // Driver: one frame with the given setting, expected items pushed
   task automatic run_frame(logic [1:0] rate, bit inv, int nbus);
      int unsigned n;
      int unsigned per;
      cfg_rate = rate;
      cfg_inv  = inv;
      @(frame_ev);
      n   = boundary;
      gap = nbus;
      per = (rate == 2'b00) ? 8 : (rate == 2'b01) ? 16 : 32;
      for (int unsigned m = n + LAT; m <= n + SPB*nbus + 2; m++) begin
         item_t it;
         int unsigned e;
         logic x2;
         e  = m - n;
         x2 = pat(e, per/2) ^ inv;
         it.cyc = m;
         it.inv = inv;
         it.v   = {pat(e, per), x2, pat(e, 32), pat(e, 16), pat(e, 4), ~pat(e, 4)};
         if (m < n + 10)                           it.ctx = "R8 realign";
         else if (m > n + (SPB/2)*nbus + 2)        it.ctx = "R9 mid-frame change";
         else                                      it.ctx = "R10 free run";
         q.push_back(it);
      end
      repeat ((SPB/2) * nbus) @(negedge clk);
      // Mid-frame change that must stay invisible until the next boundary
      cfg_rate = ~rate;
      cfg_inv  = ~inv;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_bit("R1", "reset", "sclk", sclk, 1'b0, cyc);
      check_bit("R1", "reset", "sclkx2", sclkx2, 1'b0, cyc);
      check_bit("R1", "reset", "c2", c2, 1'b0, cyc);
      check_bit("R1", "reset", "c4", c4, 1'b0, cyc);
      check_bit("R1", "reset", "c16_p", c16_p, 1'b0, cyc);
      check_bit("R7", "reset", "c16_n", c16_n, 1'b1, cyc);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      gap     = 2;
      running = 1'b1;
      run_frame(2'b00, 1'b0, 8);
      run_frame(2'b00, 1'b1, 8);
      run_frame(2'b01, 1'b0, 12);
      run_frame(2'b01, 1'b1, 16);
      run_frame(2'b10, 1'b0, 16);
      run_frame(2'b11, 1'b1, 16);
      run_frame(2'b10, 1'b1, 13);   // misaligned length: next frame jumps phase (R8)
      run_frame(2'b00, 1'b0, 7);    // misaligned again
      run_frame(2'b01, 1'b0, 8);
      while (q.size() > 0) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired got running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule